// File: doc/BRIEF.md
# Serial-Input DAC Register Interface

This block is the digital front end of a serial-input digital-to-analog converter. A word is shifted in one bit at a time, most significant bit first, into a serial shift register. The shift register advances on the rising edge of an effective clock, which is the OR of the active-low chip select and the serial clock. Either pin can therefore act as the clock while the other is held low. While chip select is high, serial clock activity is ignored.

A separate holding register drives the converter code. It is a level-sensitive latch: while the active-low load strobe is low, it passes the shift register contents through, and it keeps the last value when the strobe returns high. A new word can therefore be shifted in without disturbing the present output. An active-low clear forces the holding register to zero at any time, whatever the load strobe is doing. A power-on reset zeroes both registers. A bound checker flags a shift that happens while the load strobe is low, which is a protocol violation.

Top module: `serial_dac_regs`

## Requirements
- R1: After power-on reset, the output code is 0 and the shift register holds 0, so a load pulse with no bits shifted in still gives 0.
- R2: A word of WIDTH bits (default 12) shifted in most significant bit first, followed by a load pulse, appears on `dac_code` in natural binary: code 0 is zero scale and code 0xFFF is full scale.
- R3: While `cs_n` is high, edges on `sclk` leave the shift register unchanged.
- R4: A rising edge of `cs_n` while `sclk` is low shifts one bit, so chip select can serve as the serial clock.
- R5: While `ld_n` is low and `clr_n` is high, `dac_code` equals the shift register contents, with no clock edge required.
- R6: While `ld_n` is high, shifting a new word does not change `dac_code`.
- R7: While `clr_n` is low, `dac_code` is 0 asynchronously, whatever the level of `ld_n`.
- R8: When `clr_n` rises while `ld_n` is high, `dac_code` stays 0.
- R9: Loading and clearing leave the shift register contents unchanged: a load pulse after a clear restores the previously shifted word.
- R10: `ld_n` must be high at every shift edge; a shift while it is low is a rule violation that the checker reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low power-on reset for both registers |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select; it also acts as a clock |
| sdi | input | 1 | Serial data, most significant bit first |
| ld_n | input | 1 | Active-low load strobe; the holding register is transparent while it is low |
| clr_n | input | 1 | Active-low asynchronous clear of the holding register |
| dac_code | output | WIDTH | Code that drives the converter core |

## Verification
The bench builds the block at the default width of 12 bits. At that width all 4096 codes can be swept. Each code is shifted in, the output is checked to still show the previous code, and then the new code is loaded. Codes alternate between clocking with the serial clock and clocking with chip select, so both edge orders are covered across the full code range. Directed sequences cover the remaining cases: transparency while the load strobe is held low, a clear asserted while the latch is open, the release of the clear, and restoring the shifted word after a clear.

// File: rtl/serial_dac_regs.sv
module serial_dac_regs #(
  parameter int WIDTH = 12
) (
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic             ld_n,
  input  logic             clr_n,
  output logic [WIDTH-1:0] dac_code
);

  logic             shift_clk;
  logic [WIDTH-1:0] shreg;
  logic [WIDTH-1:0] hold;

  assign shift_clk = cs_n | sclk;

  always_ff @(posedge shift_clk or negedge rst_n)
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[WIDTH-2:0], sdi};

  always_latch
    if (!rst_n || !clr_n) hold <= '0;
    else if (!ld_n)       hold <= shreg;

  assign dac_code = hold;

endmodule

// File: rtl/serial_dac_regs_chk.sv
module serial_dac_regs_chk #(
  parameter int WIDTH = 12
) (
  input logic             rst_n,
  input logic             sclk,
  input logic             cs_n,
  input logic             sdi,
  input logic             ld_n,
  input logic             clr_n,
  input logic [WIDTH-1:0] shreg,
  input logic [WIDTH-1:0] dac_code
);

  logic        eff_clk;
  logic [15:0] bits_seen;
  logic [15:0] bits_mark;
  logic [15:0] bits_since;

  assign eff_clk    = cs_n | sclk;
  assign bits_since = bits_seen - bits_mark;

  always_ff @(posedge eff_clk or negedge rst_n)
    if (!rst_n) bits_seen <= '0;
    else        bits_seen <= bits_seen + 16'd1;

  always_ff @(posedge ld_n or negedge rst_n)
    if (!rst_n) bits_mark <= '0;
    else        bits_mark <= bits_seen;

  always @(negedge ld_n)
    if (rst_n && bits_since != 16'd0 && bits_since != 16'(WIDTH))
      $warning("load after %0d shifted bits, expected %0d", bits_since, WIDTH);

  assert_no_shift_in_load_R10: assert property (
    @(posedge eff_clk) disable iff (!rst_n) ld_n);

  assert_msb_first_shift_R2: assert property (
    @(posedge eff_clk) disable iff (!rst_n)
    1'b1 |=> (shreg[0] == $past(sdi)) && (shreg[WIDTH-1:1] == $past(shreg[WIDTH-2:0])));

  assert_load_release_capture_R5: assert property (
    @(posedge ld_n) disable iff (!rst_n) clr_n |-> dac_code == shreg);

  assert_clear_at_shift_R7: assert property (
    @(posedge eff_clk) disable iff (!rst_n) !clr_n |-> dac_code == '0);

  assert_clear_release_zero_R8: assert property (
    @(posedge clr_n) disable iff (!rst_n) dac_code == '0);

endmodule

bind serial_dac_regs serial_dac_regs_chk #(.WIDTH(WIDTH)) u_chk (
  .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .ld_n(ld_n),
  .clr_n(clr_n), .shreg(shreg), .dac_code(dac_code)
);

// File: tb/serial_dac_regs_bench.sv
module serial_dac_regs_bench;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, ld_n = 1'b1, clr_n = 1'b1;
  logic [W-1:0] dac_code;
  int checks = 0, fails = 0, bad_shifts = 0;

  always #4 clk = ~clk;

  serial_dac_regs #(.WIDTH(W)) u_serial_dac_regs (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .ld_n(ld_n), .clr_n(clr_n), .dac_code(dac_code));

  always @(posedge (cs_n | sclk)) if (rst_n && !ld_n) bad_shifts++;

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (dac_code !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, dac_code, exp);
    end
  endtask

  task automatic shift_sclk(input logic [W-1:0] w);
    @(negedge clk) cs_n = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk) begin sclk = 1'b0; sdi = w[i]; end
      @(posedge clk) sclk = 1'b1;
    end
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) sclk = 1'b0;
  endtask

  task automatic shift_cs(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk) begin cs_n = 1'b0; sdi = w[i]; end
      @(posedge clk) cs_n = 1'b1;
    end
  endtask

  task automatic pulse_load();
    @(negedge clk) ld_n = 1'b0;
    @(negedge clk) ld_n = 1'b1;
    #1;
  endtask

  task automatic run_all();
    logic [W-1:0] prev;
    repeat (3) @(negedge clk);
    #1 check("R1 reset output", '0);
    rst_n = 1'b1;
    pulse_load();
    check("R1 shift register zero after reset", '0);

    prev = '0;
    for (int c = 0; c < (1 << W); c++) begin
      if (c % 2 == 0) shift_sclk(W'(c));
      else            shift_cs(W'(c));
      #1 check("R6 hold while shifting", prev);
      pulse_load();
      check((c % 2 == 0) ? "R2 load via sclk" : "R4 load via cs clock", W'(c));
      prev = W'(c);
    end

    shift_sclk(12'hA5C);
    @(negedge clk) for (int i = 0; i < 2 * W; i++) begin
      sdi = i[0]; #1 sclk = ~sclk; #1;
    end
    sclk = 1'b0;
    @(negedge clk) ld_n = 1'b0;
    #1 check("R5 transparent while ld_n low", 12'hA5C);
    check("R3 sclk ignored while cs_n high", 12'hA5C);
    @(negedge clk) clr_n = 1'b0;
    #1 check("R7 clear while ld_n low", '0);
    @(negedge clk) ld_n = 1'b1;
    #1 check("R7 clear held while ld_n high", '0);
    @(negedge clk) clr_n = 1'b1;
    #1 check("R8 stays zero after clear release", '0);
    @(negedge clk) #1 check("R8 still zero next cycle", '0);
    pulse_load();
    check("R9 shift register kept through clear", 12'hA5C);

    shift_cs(12'h3C1);
    #1 check("R6 hold with cs clocking", 12'hA5C);
    @(negedge clk) clr_n = 1'b0;
    #1 check("R7 clear with ld_n high", '0);
    @(negedge clk) clr_n = 1'b1;
    pulse_load();
    check("R9 reload after clear", 12'h3C1);

    checks++;
    if (bad_shifts != 0) begin
      fails++;
      $display("FAIL R10 shifts with ld_n low actual %0d expected 0", bad_shifts);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule